// File: doc/BRIEF.md
# Transmit DMA bus-error handler

This controller sits inside a descriptor-driven Ethernet transmit DMA channel and takes over when the memory interface reports a bus error. It notes which transfer phase was active when the error arrived: descriptor fetch, packet data read, or descriptor write-back. It then runs the shutdown sequence that belongs to that phase. It tells the descriptor fetcher and the packet data reader to stop. It marks the frame in flight so that the MAC transmitter sends it with a bad CRC. It waits until every read already issued has returned. Where the descriptor can still be written, it closes that descriptor with its error status bit set. It then halts the channel and raises an interrupt.

A fetch-phase error differs from the other two. Descriptors already held in the channel's cache are normal, and data reads continue for them. The frame is only killed when the descriptor processor reaches the descriptor tied to the error. A write-back-phase error skips the descriptor close, because that write is the one that failed. The halted channel stays halted until software pulses `restart`. The block goes back to idle only once no read is outstanding.

The sequencer steps through the states IDLE, WAIT_DESC, KILL, DRAIN, CLOSE and HALT. Its transitions are:
- IDLE→WAIT_DESC on a fetch-phase error.
- IDLE→KILL on a data-phase or write-back-phase error.
- WAIT_DESC→KILL when `err_desc_hit` is high.
- KILL→DRAIN, always, after one cycle.
- DRAIN→CLOSE when the read count is zero and the phase is fetch or data.
- DRAIN→HALT when the read count is zero and the phase is write-back.
- CLOSE→HALT on `close_ack`.
- HALT→IDLE on `restart` while the read count is zero.

Top module: `txdma_buserr_ctrl`

## Requirements
- R1: After reset the channel is idle. All control outputs are low and `err_phase` reads 00. A `bus_err` pulse with none of `fetch_act`, `data_act` or `wb_act` high is ignored.
- R2: A bus error in idle is accepted, and the phase is recorded in `err_phase` in the next cycle. The phase is chosen by priority: write-back (code 11) over data (code 10) over fetch (code 01).
- R3: From the cycle after an accepted error until restart, `fetch_stop` is high. `burst_drop` is high for exactly that first cycle.
- R4: After a fetch-phase error, `data_stop` and `frame_corrupt` stay low until `err_desc_hit` is seen. In the next cycle `frame_corrupt` pulses for one cycle, and from then on `data_stop` is high.
- R5: After a data-phase or write-back-phase error, `data_stop` is high and `frame_corrupt` pulses for one cycle, both starting in the cycle after the error.
- R6: Each `rd_req` adds one outstanding read and each `rd_rsp` removes one. Both in the same cycle leave the count unchanged. While the count is non-zero the sequence neither requests a close nor halts.
- R7: For fetch-phase and data-phase errors, `close_req` rises once the reads have drained and is held until `close_ack`. While it is high, `close_word` has only bit 27 set.
- R8: For a write-back-phase error, `close_req` is never raised, and the channel halts in the cycle after the reads have drained.
- R9: On entering the halted state, `chan_stopped` goes high and `irq` pulses for exactly one cycle. `chan_stopped` stays high until a restart is accepted.
- R10: Further bus errors during the shutdown sequence or while halted are ignored, and the first recorded `err_phase` is kept.
- R11: `restart` takes effect only while the channel is halted and no read is outstanding. It then returns the channel to idle with `err_phase` 00 and `fetch_stop` low. A restart at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_err | input | 1 | Bus error response from the memory interface |
| fetch_act | input | 1 | Descriptor fetch is in progress |
| data_act | input | 1 | Packet data read is in progress |
| wb_act | input | 1 | Descriptor write-back is in progress |
| rd_req | input | 1 | A read request was issued this cycle |
| rd_rsp | input | 1 | A read response (good or error) returned this cycle |
| err_desc_hit | input | 1 | The descriptor processor reached the descriptor tied to the fetch error |
| close_ack | input | 1 | The error-close write has been accepted |
| restart | input | 1 | Software restart of a halted channel |
| fetch_stop | output | 1 | Stop issuing descriptor fetches |
| data_stop | output | 1 | Stop issuing packet data reads |
| burst_drop | output | 1 | Discard the descriptors not yet fetched in the current burst |
| frame_corrupt | output | 1 | Terminate the current frame and tag it for a bad CRC |
| close_req | output | 1 | Request the descriptor close with error status |
| close_word | output | 32 | Status word for the close, error bit set |
| chan_stopped | output | 1 | The channel is halted by a bus error |
| irq | output | 1 | One-cycle pulse on entering the halted state |
| err_phase | output | 2 | Sticky phase of the first error (01 fetch, 10 data, 11 write-back) |

## Verification
The bench draws random combinations of phase flags, read counts and handshake delays. Every case is checked against the phase-priority and drain rules.

The bench goes after the following corner cases:
- Several phase flags high at once. A wrong priority would record the wrong code and run the wrong sequence.
- Holding back `err_desc_hit` on a fetch error. A design that stopped data reads early would starve the cached normal descriptors.
- A fetch error with zero outstanding reads. This exposes a KILL state that skips DRAIN, and also off-by-one drain logic that closes while reads are still pending.
- Extra errors and early restarts during the sequence. A design that accepted them would overwrite `err_phase` or leave HALT too soon.
- A stray read left outstanding in HALT. A restart must not return the channel to idle while that read is open.

// File: rtl/txbe_pkg.sv
package txbe_pkg;

    typedef enum logic [1:0] {
        PH_NONE  = 2'b00,
        PH_FETCH = 2'b01,
        PH_DATA  = 2'b10,
        PH_WB    = 2'b11
    } err_phase_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_DESC,
        ST_KILL,
        ST_DRAIN,
        ST_CLOSE,
        ST_HALT
    } seq_state_t;

endpackage

// File: rtl/txbe_phase_sel.sv
module txbe_phase_sel
    import txbe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fetch_act,
    input  logic       data_act,
    input  logic       wb_act,
    input  logic       capture,
    input  logic       clear,
    output err_phase_t hit_phase,
    output err_phase_t phase_q
);

    // priority: write-back over data over fetch
    always_comb begin
        if (wb_act)
            hit_phase = PH_WB;
        else if (data_act)
            hit_phase = PH_DATA;
        else if (fetch_act)
            hit_phase = PH_FETCH;
        else
            hit_phase = PH_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= PH_NONE;
        else if (clear)
            phase_q <= PH_NONE;
        else if (capture)
            phase_q <= hit_phase;
    end

    // the recorded phase changes only on a capture or a clear
    assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !clear) |=> $stable(phase_q));

endmodule

// File: rtl/txbe_rd_tracker.sv
module txbe_rd_tracker #(
    parameter int MAX_OUT = 16,
    localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic rd_rsp,
    output logic drained
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else begin
            unique case ({rd_req, rd_rsp})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign drained = (cnt_q == '0);

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rsp && !rd_req) |-> !drained);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_rsp) |-> (cnt_q != CNT_W'(MAX_OUT)));

endmodule

// File: rtl/txbe_fsm.sv
module txbe_fsm
    import txbe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_err,
    input  err_phase_t hit_phase,
    input  err_phase_t phase_q,
    input  logic       err_desc_hit,
    input  logic       drained,
    input  logic       close_ack,
    input  logic       restart,
    output logic       capture,
    output logic       clear,
    output logic       fetch_stop,
    output logic       data_stop,
    output logic       burst_drop,
    output logic       frame_corrupt,
    output logic       close_req,
    output logic       chan_stopped,
    output logic       irq
);

    seq_state_t state_q, state_d;
    logic       burst_q, irq_q;

    assign capture = (state_q == ST_IDLE) && bus_err && (hit_phase != PH_NONE);
    assign clear   = (state_q == ST_HALT) && restart && drained;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (capture)
                              state_d = (hit_phase == PH_FETCH) ? ST_WAIT_DESC : ST_KILL;
            ST_WAIT_DESC: if (err_desc_hit) state_d = ST_KILL;
            ST_KILL:      state_d = ST_DRAIN;
            ST_DRAIN:     if (drained)
                              state_d = (phase_q == PH_WB) ? ST_HALT : ST_CLOSE;
            ST_CLOSE:     if (close_ack) state_d = ST_HALT;
            ST_HALT:      if (clear) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register and registered pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            burst_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            burst_q <= capture;
            irq_q   <= (state_d == ST_HALT) && (state_q != ST_HALT);
        end
    end

    // outputs
    always_comb begin
        fetch_stop    = 1'b0;
        data_stop     = 1'b0;
        frame_corrupt = 1'b0;
        close_req     = 1'b0;
        chan_stopped  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT_DESC: fetch_stop = 1'b1;
            ST_KILL: begin
                fetch_stop    = 1'b1;
                data_stop     = 1'b1;
                frame_corrupt = 1'b1;
            end
            ST_DRAIN: begin
                fetch_stop = 1'b1;
                data_stop  = 1'b1;
            end
            ST_CLOSE: begin
                fetch_stop = 1'b1;
                data_stop  = 1'b1;
                close_req  = 1'b1;
            end
            ST_HALT: begin
                fetch_stop   = 1'b1;
                data_stop    = 1'b1;
                chan_stopped = 1'b1;
            end
            default: ;
        endcase
        burst_drop = burst_q;
        irq        = irq_q;
    end

    assert_kill_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_corrupt |=> !frame_corrupt);

    assert_phase_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && $past(state_q != ST_IDLE)) |-> $stable(phase_q));

    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_stopped && !restart) |=> chan_stopped);

endmodule

// File: rtl/txdma_buserr_ctrl.sv
module txdma_buserr_ctrl
    import txbe_pkg::*;
#(
    parameter int DESC_W  = 32,
    parameter int ERR_BIT = 27,
    parameter int MAX_OUT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_err,
    input  logic              fetch_act,
    input  logic              data_act,
    input  logic              wb_act,
    input  logic              rd_req,
    input  logic              rd_rsp,
    input  logic              err_desc_hit,
    input  logic              close_ack,
    input  logic              restart,
    output logic              fetch_stop,
    output logic              data_stop,
    output logic              burst_drop,
    output logic              frame_corrupt,
    output logic              close_req,
    output logic [DESC_W-1:0] close_word,
    output logic              chan_stopped,
    output logic              irq,
    output logic [1:0]        err_phase
);

    localparam logic [DESC_W-1:0] CLOSE_WORD = {{(DESC_W-1){1'b0}}, 1'b1} << ERR_BIT;

    err_phase_t hit_phase, phase_q;
    logic       capture, clear, drained;

    txbe_phase_sel u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_act (fetch_act),
        .data_act  (data_act),
        .wb_act    (wb_act),
        .capture   (capture),
        .clear     (clear),
        .hit_phase (hit_phase),
        .phase_q   (phase_q)
    );

    txbe_rd_tracker #(.MAX_OUT(MAX_OUT)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .rd_rsp  (rd_rsp),
        .drained (drained)
    );

    txbe_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_err       (bus_err),
        .hit_phase     (hit_phase),
        .phase_q       (phase_q),
        .err_desc_hit  (err_desc_hit),
        .drained       (drained),
        .close_ack     (close_ack),
        .restart       (restart),
        .capture       (capture),
        .clear         (clear),
        .fetch_stop    (fetch_stop),
        .data_stop     (data_stop),
        .burst_drop    (burst_drop),
        .frame_corrupt (frame_corrupt),
        .close_req     (close_req),
        .chan_stopped  (chan_stopped),
        .irq           (irq)
    );

    assign close_word = close_req ? CLOSE_WORD : '0;
    assign err_phase  = phase_q;

    assert_close_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
        close_req |-> drained);

    assert_wb_no_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WB) |-> !close_req);

    assert_irq_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> chan_stopped);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_NONE) |-> (!fetch_stop && !chan_stopped));

endmodule

// File: tb/txdma_buserr_ctrl_test.sv
module txdma_buserr_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_err = 0, fetch_act = 0, data_act = 0, wb_act = 0;
    logic        rd_req = 0, rd_rsp = 0, err_desc_hit = 0, close_ack = 0, restart = 0;
    logic        fetch_stop, data_stop, burst_drop, frame_corrupt, close_req;
    logic [31:0] close_word;
    logic        chan_stopped, irq;
    logic [1:0]  err_phase;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    txdma_buserr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_err(bus_err), .fetch_act(fetch_act),
        .data_act(data_act), .wb_act(wb_act), .rd_req(rd_req), .rd_rsp(rd_rsp),
        .err_desc_hit(err_desc_hit), .close_ack(close_ack), .restart(restart),
        .fetch_stop(fetch_stop), .data_stop(data_stop), .burst_drop(burst_drop),
        .frame_corrupt(frame_corrupt), .close_req(close_req), .close_word(close_word),
        .chan_stopped(chan_stopped), .irq(irq), .err_phase(err_phase)
    );

    function automatic logic [1:0] exp_phase(input logic [2:0] acts); // {wb,data,fetch}
        if (acts[2]) return 2'b11;
        if (acts[1]) return 2'b10;
        if (acts[0]) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] exp_close_word();
        return 32'h1 << 27;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        bus_err = 0; fetch_act = 0; data_act = 0; wb_act = 0;
        rd_req = 0; rd_rsp = 0; err_desc_hit = 0; close_ack = 0; restart = 0;
    endtask

    task automatic run_case(input logic [2:0] acts, input int nrd,
                            input int hit_dly, input int ack_dly, input bit stray);
        logic [1:0] ph;
        ph = exp_phase(acts);
        // issue outstanding reads
        for (int i = 0; i < nrd; i++) begin
            rd_req = 1; step();
        end
        rd_req = 0;
        {wb_act, data_act, fetch_act} = acts;
        bus_err = 1;
        step();
        clear_in();
        chk(err_phase == ph, "R2", "err_phase", err_phase, ph);
        chk(fetch_stop == 1, "R3", "fetch_stop", fetch_stop, 1);
        chk(burst_drop == 1, "R3", "burst_drop first cycle", burst_drop, 1);
        if (ph == 2'b01) begin
            for (int k = 0; k < hit_dly; k++) begin
                bus_err = $urandom_range(0, 1); data_act = 1;
                restart = $urandom_range(0, 1);
                step();
                clear_in();
                chk(data_stop == 0, "R4", "data_stop while waiting", data_stop, 0);
                chk(frame_corrupt == 0, "R4", "frame_corrupt early", frame_corrupt, 0);
                chk(err_phase == ph, "R10", "phase kept", err_phase, ph);
                chk(burst_drop == 0, "R3", "burst_drop pulse length", burst_drop, 0);
            end
            err_desc_hit = 1;
            step();
            clear_in();
            chk(frame_corrupt == 1, "R4", "frame_corrupt after hit", frame_corrupt, 1);
            chk(data_stop == 1, "R4", "data_stop after hit", data_stop, 1);
        end else begin
            chk(frame_corrupt == 1, "R5", "frame_corrupt", frame_corrupt, 1);
            chk(data_stop == 1, "R5", "data_stop", data_stop, 1);
        end
        // drain: KILL lasts one cycle, responses return one per cycle
        for (int i = 0; i < nrd; i++) begin
            rd_rsp = 1; bus_err = 1; wb_act = 1; restart = $urandom_range(0, 1);
            step();
            clear_in();
            chk(frame_corrupt == 0, "R4", "single kill pulse", frame_corrupt, 0);
            chk(close_req == 0 && chan_stopped == 0, "R6", "no close while reads open",
                {close_req, chan_stopped}, 0);
            chk(err_phase == ph, "R10", "phase kept in drain", err_phase, ph);
        end
        if (nrd == 0) begin
            step();
            chk(close_req == 0 && chan_stopped == 0, "R6", "drain state",
                {close_req, chan_stopped}, 0);
        end
        step();
        if (ph == 2'b11) begin
            chk(close_req == 0, "R8", "no close on write-back", close_req, 0);
            chk(chan_stopped == 1, "R8", "halt after drain", chan_stopped, 1);
            chk(irq == 1, "R9", "irq on halt", irq, 1);
        end else begin
            chk(close_req == 1, "R7", "close_req", close_req, 1);
            chk(close_word == exp_close_word(), "R7", "close_word", close_word, exp_close_word());
            for (int k = 0; k < ack_dly; k++) begin
                step();
                chk(close_req == 1 && chan_stopped == 0, "R7", "close held",
                    {close_req, chan_stopped}, 2);
            end
            close_ack = 1;
            step();
            clear_in();
            chk(close_req == 0, "R7", "close dropped", close_req, 0);
            chk(chan_stopped == 1, "R9", "chan_stopped", chan_stopped, 1);
            chk(irq == 1, "R9", "irq on halt", irq, 1);
        end
        // halted: extra error ignored, irq one cycle
        bus_err = 1; {wb_act, data_act, fetch_act} = 3'b111;
        step();
        clear_in();
        chk(irq == 0, "R9", "irq single pulse", irq, 0);
        chk(chan_stopped == 1, "R9", "stays halted", chan_stopped, 1);
        chk(err_phase == ph, "R10", "phase kept in halt", err_phase, ph);
        if (stray) begin
            rd_req = 1; step(); rd_req = 0;
            restart = 1; step(); restart = 0;
            chk(chan_stopped == 1, "R11", "restart blocked by open read", chan_stopped, 1);
            rd_rsp = 1; step(); rd_rsp = 0;
        end
        restart = 1;
        step();
        restart = 0;
        chk(chan_stopped == 0 && fetch_stop == 0 && data_stop == 0, "R11", "back to idle",
            {chan_stopped, fetch_stop, data_stop}, 0);
        chk(err_phase == 2'b00, "R11", "phase cleared", err_phase, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        clear_in();
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
        chk({fetch_stop, data_stop, burst_drop, frame_corrupt, close_req, chan_stopped, irq} == 0,
            "R1", "reset outputs",
            {fetch_stop, data_stop, burst_drop, frame_corrupt, close_req, chan_stopped, irq}, 0);
        chk(err_phase == 2'b00, "R1", "reset phase", err_phase, 0);
        // error with no phase active is ignored
        bus_err = 1; step(); clear_in(); step();
        chk(fetch_stop == 0 && err_phase == 0 && burst_drop == 0, "R1", "idle error ignored",
            {fetch_stop, err_phase, burst_drop}, 0);
        // restart while idle is ignored
        restart = 1; step(); clear_in();
        chk(fetch_stop == 0 && chan_stopped == 0, "R11", "idle restart", fetch_stop, 0);
        // simultaneous request and response keep the count
        rd_req = 1; rd_rsp = 0; step();
        rd_req = 1; rd_rsp = 1; step();
        clear_in();
        // count is 1: a data error must hold in drain until one response
        data_act = 1; bus_err = 1; step(); clear_in();
        step(); step();
        chk(close_req == 0, "R6", "same-cycle req/rsp kept count", close_req, 0);
        rd_rsp = 1; step(); rd_rsp = 0;
        step();
        chk(close_req == 1, "R6", "close after last response", close_req, 1);
        close_ack = 1; step(); clear_in();
        restart = 1; step(); clear_in();
        chk(chan_stopped == 0, "R11", "restart", chan_stopped, 0);
        // directed corners
        run_case(3'b001, 0, 0, 0, 1'b0);
        run_case(3'b001, 3, 4, 2, 1'b1);
        run_case(3'b111, 2, 0, 0, 1'b0);
        run_case(3'b011, 0, 0, 3, 1'b1);
        run_case(3'b100, 0, 0, 0, 1'b1);
        // constrained random
        for (int n = 0; n < 40; n++) begin
            run_case(3'($urandom_range(1, 7)), $urandom_range(0, 6),
                     $urandom_range(0, 5), $urandom_range(0, 4), 1'($urandom_range(0, 1)));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule